// File: doc/BRIEF.md
# Register Rename Status Table

This block is the register-status table of an out-of-order floating-point core that renames registers by producer tag. Instructions pass through issue one per cycle, in program order. For each issuing instruction the table answers two source-register lookups in the same cycle. Each answer is either a ready 64-bit value, or the 4-bit tag of the reservation station that will produce the value later. When the instruction writes a register, the table records the issuing station's tag as that register's new pending producer. An older producer still in flight is therefore forgotten.

Results come back on a broadcast result bus that carries a value and the tag of the station that produced it. Every register whose pending tag equals the broadcast tag takes the value and returns to the "valid" state, shown by tag 0. Because write-back is decided only by tag equality, an older in-flight result is ignored when its register has since been renamed to a newer producer. A source lookup in the same cycle as a matching broadcast is forwarded the broadcast value. Both the issue port and the result bus carry only a valid strobe and no ready. The table takes an issue and a broadcast in every cycle, so it never applies back-pressure. Upstream logic must only present an issue once a reservation station has been allocated for it.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reads back as ready (`srcN_ready`=1, `srcN_tag`=0) with value 0.
- R2: A source register whose pending tag is 0 reads as ready with tag output 0 and its stored value, in the same cycle as the lookup.
- R3: A source register whose pending tag is nonzero, and which is not matched by the current broadcast, reads as not ready, and `srcN_tag` gives that pending tag.
- R4: An issue with `iss_valid`=1 and `iss_dst_en`=1 makes `iss_tag` the pending tag of register `iss_dst` from the next cycle on. Source lookups in the issuing cycle see the table as it was before this issue.
- R5: A broadcast with `bc_valid`=1 and nonzero `bc_tag` writes `bc_data` into every register whose pending tag equals `bc_tag` and clears those tags to 0, all visible from the next cycle.
- R6: A broadcast whose tag equals no register's pending tag changes no register. This covers a stale result from a producer that a later issue has replaced.
- R7: When an issue targets a register in the same cycle as a broadcast matching that register's old tag, the register takes the new tag and keeps its old value.
- R8: A source lookup in the same cycle as a broadcast that matches the register's pending tag returns ready, tag 0 and `bc_data`.
- R9: A broadcast with `bc_tag`=0 writes nothing and forwards nothing.
- R10: An issue with `iss_valid`=0 or `iss_dst_en`=0 changes no pending tag.
- R11: `iss_tag` is nonzero whenever `iss_valid` and `iss_dst_en` are both 1. Tag 0 is reserved for "value valid".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src1 | input | 4 | First source register index |
| iss_src2 | input | 4 | Second source register index |
| iss_dst_en | input | 1 | The issuing instruction writes a register |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Tag of the reservation station taking the instruction (nonzero) |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | 4 | Tag of the station that produced the result |
| bc_data | input | 64 | Broadcast result value |
| src1_ready | output | 1 | First source value is available |
| src1_tag | output | 4 | Pending producer tag of the first source (0 when ready) |
| src1_value | output | 64 | First source value, meaningful when ready |
| src2_ready | output | 1 | Second source value is available |
| src2_tag | output | 4 | Pending producer tag of the second source (0 when ready) |
| src2_value | output | 64 | Second source value, meaningful when ready |

## Verification
The bench builds the table with its default parameters: 16 registers, 64-bit values and 4-bit tags. With only 15 usable tags and random destinations, one tag often ends up pending in several registers. A single broadcast then writes several registers at once. Broadcast tags are drawn mostly from tags that are currently pending, so forwarding, same-cycle rename against write-back, and stale results after a rename all occur many times, next to directed sequences that force each of them.

// File: rtl/rst_pkg.sv
package rst_pkg;
  // Default geometry of the status table
  localparam int unsigned DEF_NREG = 16;
  localparam int unsigned DEF_DW   = 64;
  localparam int unsigned DEF_TW   = 4;
  // Number of source lookups answered per issue
  localparam int unsigned NSRC     = 2;

  typedef enum logic {
    SRC_WAIT  = 1'b0,
    SRC_AVAIL = 1'b1
  } src_state_e;
endpackage

// File: rtl/rst_dst_decode.sv
module rst_dst_decode #(
  parameter int unsigned NREG = 16,
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic            iss_valid,
  input  logic            iss_dst_en,
  input  logic [RW-1:0]   iss_dst,
  output logic [NREG-1:0] set_en
);
  for (genvar r = 0; r < NREG; r++) begin : g_dec
    assign set_en[r] = iss_valid && iss_dst_en && (iss_dst == RW'(r));
  end
endmodule

// File: rtl/rst_entry.sv
module rst_entry #(
  parameter int unsigned DW = 64,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [TW-1:0] set_tag,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic [TW-1:0] tag_q,
  output logic [DW-1:0] val_q
);
  logic hit;
  assign hit = bc_valid && (bc_tag != '0) && (bc_tag == tag_q);

  // Pending producer: a rename beats a completing write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (set_en) begin
      tag_q <= set_tag;
    end else if (hit) begin
      tag_q <= '0;
    end
  end

  // Architectural value: written only by a write-back that is not overtaken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (hit && !set_en) begin
      val_q <= bc_data;
    end
  end

  p_rename_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tag_q == $past(set_tag));
  p_writeback_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !set_en) |=> (tag_q == '0) && (val_q == $past(bc_data)));
  p_no_match_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !set_en) |=> $stable(tag_q) && $stable(val_q));
  p_issue_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && set_en) |=> $stable(val_q));
  p_zero_tag_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag == '0) |=> $stable(val_q));
endmodule

// File: rtl/rst_read_port.sv
module rst_read_port
  import rst_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 64,
  parameter int unsigned TW   = 4,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic [RW-1:0]            sel,
  input  logic [NREG-1:0][TW-1:0]  tag_all,
  input  logic [NREG-1:0][DW-1:0]  val_all,
  input  logic                     bc_valid,
  input  logic [TW-1:0]            bc_tag,
  input  logic [DW-1:0]            bc_data,
  output logic                     rdy,
  output logic [TW-1:0]            tag,
  output logic [DW-1:0]            val
);
  logic [TW-1:0] cur_tag;
  logic [DW-1:0] cur_val;
  logic          fwd;
  src_state_e    st;

  always_comb begin
    cur_tag = tag_all[sel];
    cur_val = val_all[sel];
    fwd     = bc_valid && (bc_tag != '0) && (bc_tag == cur_tag);
    st      = ((cur_tag == '0) || fwd) ? SRC_AVAIL : SRC_WAIT;
    rdy     = (st == SRC_AVAIL);
    tag     = fwd ? '0 : cur_tag;
    val     = fwd ? bc_data : cur_val;
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned TW   = DEF_TW,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [RW-1:0] iss_src1,
  input  logic [RW-1:0] iss_src2,
  input  logic          iss_dst_en,
  input  logic [RW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic          src1_ready,
  output logic [TW-1:0] src1_tag,
  output logic [DW-1:0] src1_value,
  output logic          src2_ready,
  output logic [TW-1:0] src2_tag,
  output logic [DW-1:0] src2_value
);
  logic [NREG-1:0]          set_en;
  logic [NREG-1:0][TW-1:0]  tag_all;
  logic [NREG-1:0][DW-1:0]  val_all;
  logic [NSRC-1:0][RW-1:0]  rd_sel;
  logic [NSRC-1:0]          rd_rdy;
  logic [NSRC-1:0][TW-1:0]  rd_tag;
  logic [NSRC-1:0][DW-1:0]  rd_val;

  rst_dst_decode #(.NREG(NREG)) u_dec (
    .iss_valid  (iss_valid),
    .iss_dst_en (iss_dst_en),
    .iss_dst    (iss_dst),
    .set_en     (set_en)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    rst_entry #(.DW(DW), .TW(TW)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en[r]),
      .set_tag  (iss_tag),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .tag_q    (tag_all[r]),
      .val_q    (val_all[r])
    );
  end

  assign rd_sel[0] = iss_src1;
  assign rd_sel[1] = iss_src2;

  for (genvar p = 0; p < NSRC; p++) begin : g_rd
    rst_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd (
      .sel      (rd_sel[p]),
      .tag_all  (tag_all),
      .val_all  (val_all),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .rdy      (rd_rdy[p]),
      .tag      (rd_tag[p]),
      .val      (rd_val[p])
    );
  end

  assign src1_ready = rd_rdy[0];
  assign src1_tag   = rd_tag[0];
  assign src1_value = rd_val[0];
  assign src2_ready = rd_rdy[1];
  assign src2_tag   = rd_tag[1];
  assign src2_value = rd_val[1];

  p_issue_tag_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_dst_en) |-> (iss_tag != '0));
  p_dst_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_dst_en) |=> tag_all[$past(iss_dst)] == $past(iss_tag));
  p_bypass_src1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != '0 && bc_tag == tag_all[iss_src1])
      |-> (src1_ready && src1_tag == '0 && src1_value == bc_data));
  p_pending_src2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_all[iss_src2] != '0 && !(bc_valid && bc_tag == tag_all[iss_src2]))
      |-> (!src2_ready && src2_tag == tag_all[iss_src2]));
  p_no_dst_no_rename_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(iss_valid && iss_dst_en) && !bc_valid) |=> $stable(tag_all));
endmodule

// File: tb/sim_rename_status_table.sv
`timescale 1ns/1ps
module sim_rename_status_table;
  localparam int NREG = 16;
  localparam int DW   = 64;
  localparam int TW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0, iss_dst_en = 1'b0;
  logic [3:0]    iss_src1 = '0, iss_src2 = '0, iss_dst = '0, iss_tag = 4'd1;
  logic          bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic          src1_ready, src2_ready;
  logic [TW-1:0] src1_tag, src2_tag;
  logic [DW-1:0] src1_value, src2_value;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [TW-1:0] m_tag [NREG];
  logic [DW-1:0] m_val [NREG];

  always #4 clk = ~clk;

  rename_status_table u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src1_ready(src1_ready), .src1_tag(src1_tag), .src1_value(src1_value),
    .src2_ready(src2_ready), .src2_tag(src2_tag), .src2_value(src2_value)
  );

  // Expected lookup from the reference table plus the current broadcast
  function automatic logic exp_rdy(input logic [3:0] s);
    return (m_tag[s] == '0) || (bc_valid && bc_tag != '0 && bc_tag == m_tag[s]);
  endfunction
  function automatic logic [DW-1:0] exp_val(input logic [3:0] s);
    if (m_tag[s] != '0 && bc_valid && bc_tag == m_tag[s]) return bc_data;
    return m_val[s];
  endfunction

  task automatic check_src(input string req, input int idx, input logic rdy,
                           input logic [TW-1:0] tg, input logic [DW-1:0] v,
                           input logic [3:0] s);
    logic er;
    er = exp_rdy(s);
    n_run++;
    if (rdy !== er) begin
      n_fail++;
      $display("FAIL %s src%0d ready act=%0b exp=%0b", req, idx, rdy, er);
    end else if (er && (tg !== '0 || v !== exp_val(s))) begin
      n_fail++;
      $display("FAIL %s src%0d value act=%h/%0d exp=%h/0", req, idx, v, tg, exp_val(s));
    end else if (!er && tg !== m_tag[s]) begin
      n_fail++;
      $display("FAIL %s src%0d tag act=%0d exp=%0d", req, idx, tg, m_tag[s]);
    end
  endtask

  task automatic model_update();
    for (int r = 0; r < NREG; r++) begin
      logic hit;
      hit = bc_valid && bc_tag != '0 && bc_tag == m_tag[r];
      if (iss_valid && iss_dst_en && iss_dst == 4'(r)) m_tag[r] = iss_tag;
      else if (hit) begin
        m_tag[r] = '0;
        m_val[r] = bc_data;
      end
    end
  endtask

  // One cycle: inputs applied after a falling edge, outputs checked, then the edge
  task automatic step(input string req, input logic iv, input logic [3:0] s1,
                      input logic [3:0] s2, input logic de, input logic [3:0] d,
                      input logic [3:0] t, input logic cv, input logic [3:0] ct,
                      input logic [DW-1:0] cd);
    iss_valid = iv; iss_src1 = s1; iss_src2 = s2; iss_dst_en = de;
    iss_dst = d; iss_tag = t; bc_valid = cv; bc_tag = ct; bc_data = cd;
    #1;
    check_src(req, 1, src1_ready, src1_tag, src1_value, s1);
    check_src(req, 2, src2_ready, src2_tag, src2_value, s2);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic expect_tag(input string req, input logic [3:0] r,
                            input logic [TW-1:0] t, input logic [DW-1:0] v);
    step(req, 1'b0, r, r, 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, '0);
    n_run++;
    if (t == '0 ? (src1_ready !== 1'b1 || src1_value !== v) : (src1_tag !== t)) begin
      n_fail++;
      $display("FAIL %s reg%0d act=%0d/%h exp=%0d/%h", req, r, src1_tag, src1_value, t, v);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2013));
    for (int r = 0; r < NREG; r++) begin m_tag[r] = '0; m_val[r] = '0; end
    @(negedge clk);
    // R1: reset state, read while reset is held
    for (int r = 0; r < NREG; r++) begin
      iss_src1 = 4'(r); iss_src2 = 4'(NREG - 1 - r);
      #1;
      check_src("R1", 1, src1_ready, src1_tag, src1_value, 4'(r));
      check_src("R1", 2, src2_ready, src2_tag, src2_value, 4'(NREG - 1 - r));
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: rename reg3 to tag 5; same-cycle lookup of reg3 still sees the old state
    step("R4", 1'b1, 4'd3, 4'd3, 1'b1, 4'd3, 4'd5, 1'b0, 4'd0, '0);
    expect_tag("R3", 4'd3, 4'd5, '0);
    // R8: broadcast tag 5 forwards to a lookup in the same cycle
    step("R8", 1'b1, 4'd3, 4'd7, 1'b0, 4'd0, 4'd1, 1'b1, 4'd5, 64'hAAAA_0000_0000_0005);
    expect_tag("R5", 4'd3, 4'd0, 64'hAAAA_0000_0000_0005);
    // R7: rename reg3 to tag 6 while tag 5 (its old producer) broadcasts
    step("R4", 1'b1, 4'd2, 4'd2, 1'b1, 4'd3, 4'd5, 1'b0, 4'd0, '0);
    step("R7", 1'b1, 4'd1, 4'd1, 1'b1, 4'd3, 4'd6, 1'b1, 4'd5, 64'hDEAD_BEEF_0000_0001);
    expect_tag("R7", 4'd3, 4'd6, '0);
    // R6: stale result of tag 5 arrives again and is ignored
    step("R6", 1'b0, 4'd3, 4'd3, 1'b0, 4'd0, 4'd1, 1'b1, 4'd5, 64'h1111);
    expect_tag("R6", 4'd3, 4'd6, '0);
    // R10: issue without destination and idle issue with destination enable
    step("R10", 1'b1, 4'd0, 4'd0, 1'b0, 4'd3, 4'd9, 1'b0, 4'd0, '0);
    step("R10", 1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 4'd9, 1'b0, 4'd0, '0);
    expect_tag("R10", 4'd3, 4'd6, '0);
    // R9: tag 0 broadcast neither writes nor forwards
    step("R9", 1'b0, 4'd4, 4'd4, 1'b0, 4'd0, 4'd1, 1'b1, 4'd0, 64'h9999);
    expect_tag("R9", 4'd4, 4'd0, '0);
    // R5: one broadcast completes two registers renamed to the same tag
    step("R4", 1'b1, 4'd8, 4'd9, 1'b1, 4'd8, 4'd12, 1'b0, 4'd0, '0);
    step("R4", 1'b1, 4'd8, 4'd9, 1'b1, 4'd9, 4'd12, 1'b0, 4'd0, '0);
    step("R5", 1'b0, 4'd8, 4'd9, 1'b0, 4'd0, 4'd1, 1'b1, 4'd12, 64'h0C0C_0C0C);
    expect_tag("R5", 4'd8, 4'd0, 64'h0C0C_0C0C);
    expect_tag("R2", 4'd9, 4'd0, 64'h0C0C_0C0C);
    step("R5", 1'b0, 4'd3, 4'd3, 1'b0, 4'd0, 4'd1, 1'b1, 4'd6, 64'h6666);
    expect_tag("R2", 4'd3, 4'd0, 64'h6666);

    // Random traffic: R2 R3 R4 R5 R6 R7 R8 R9 R10 against the reference table
    for (int i = 0; i < 3000; i++) begin
      logic iv, de, cv;
      logic [3:0] s1, s2, d, t, ct;
      logic [DW-1:0] cd;
      iv = ($urandom_range(99) < 80);
      de = ($urandom_range(99) < 85);
      s1 = 4'($urandom_range(NREG - 1));
      s2 = 4'($urandom_range(NREG - 1));
      d  = 4'($urandom_range(NREG - 1));
      t  = 4'($urandom_range(15, 1));
      cv = ($urandom_range(99) < 70);
      if ($urandom_range(99) < 65) ct = m_tag[$urandom_range(NREG - 1)];
      else ct = 4'($urandom_range(15));
      cd = {$urandom, $urandom};
      step("R2-random", iv, s1, s2, de, d, t, cv, ct, cd);
    end
    finish_up();
  end
endmodule